// File: doc/BRIEF.md
# Timestamped Hit Collector with Token-Passed Serial Readout

This block gathers hits from a bank of detector channels and turns each one into a packed event word. A hit arrives as a one-cycle strobe on a channel together with that channel's peak amplitude. The block captures the amplitude and the current value of a free-running timestamp counter at that moment. It marks the channel pending until the event has been moved into a shared event FIFO. One pending channel is moved per clock, and a round-robin arbiter chooses among several.

The FIFO drains through a one-bit serial line. Several chips share that line through a daisy-chained token. A chip drives the line only while it holds the token. It keeps the token until its FIFO is empty and then hands the token to the next chip with a one-cycle pulse. When the FIFO is full, new events wait in their channel's pending slot. They are not dropped and no stored entry is overwritten.

Top module: `evt_stamp_fifo`

## Requirements
- R1: Each event word is {channel index, amplitude, timestamp}, with the channel index in the most significant IDX_W bits and the timestamp in the least significant TS_W bits. With the defaults (64 channels, 6-bit amplitude, TS_W = 18) the word is 30 bits.
- R2: The timestamp counter reads 0 in the first cycle after reset and adds 1 every clock. After its all-ones value it returns to 0. An event carries the counter value of the cycle in which its strobe is sampled.
- R3: A strobe on a channel that is not pending latches that channel's amplitude and timestamp and makes it pending. A strobe on a channel that is already pending is ignored, and the first captured data are kept.
- R4: At most one pending channel is written into the FIFO per clock, in the cycle after its strobe at the earliest, and its pending mark is cleared. Among several pending channels, the search starts at the channel after the one last written and wraps around the channel range. After reset, the search starts at channel 0.
- R5: The FIFO holds DEPTH (default 64, a power of two) words and returns them in write order. While it is full, no write occurs. Pending channels stay pending and are written once space frees up.
- R6: tok_in is a one-cycle pulse that hands this chip the token. If the FIFO is empty, tok_out pulses high for exactly one cycle, on the clock after the one that sampled tok_in.
- R7: With data present, the first bit goes out on the clock after the one that sampled tok_in. Words follow back to back with no idle cycle, and the chip keeps the token until the FIFO is empty. tok_out pulses in the cycle right after the last bit, and ser_en is low in that cycle.
- R8: Serial words go out MSB first, one bit per clock, WORD_W bits per word. ser_frame is high only on the first bit of each word.
- R9: After reset, ser_en, ser_frame and tok_out are low, and the chip holds no token.
- R10: ser_en stays low while the chip does not hold the token, even when the FIFO holds words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_strobe | input | CHANNELS | One-cycle hit strobe per channel |
| hit_amp | input | CHANNELS*AMP_W | Peak amplitude per channel, channel c at bits c*AMP_W upward |
| tok_in | input | 1 | Token arrival pulse from the previous chip |
| tok_out | output | 1 | Token hand-off pulse to the next chip |
| ser_en | output | 1 | High while this chip drives the shared serial line |
| ser_bit | output | 1 | Serial data, MSB first |
| ser_frame | output | 1 | High on the first bit of each word |

## Verification
The bench fills the FIFO to the brim and then strikes more channels, including repeat strikes on channels that are already waiting. A design that overwrote entries would lose the oldest words, and one that accepted repeat strikes would show the later amplitude. Simultaneous strikes are checked for the wrapped search order, so a fixed-priority arbiter would send channel 1 ahead of channel 12. Strikes across the counter rollover check that the timestamp comes back to zero. Token timing is checked to the exact cycle for an empty FIFO and for long back-to-back readouts, which exposes a lost cycle between words or an early hand-off.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int unsigned DEF_CHANNELS = 64;
    localparam int unsigned DEF_AMP_W    = 6;
    localparam int unsigned DEF_TS_W     = 18;
    localparam int unsigned DEF_DEPTH    = 64;

    typedef enum logic [0:0] {
        TOK_WAIT = 1'b0,
        TOK_HOLD = 1'b1
    } tok_state_e;

endpackage

// File: rtl/evt_hit_latch.sv
module evt_hit_latch #(
    parameter  int unsigned CHANNELS = 64,
    parameter  int unsigned AMP_W    = 6,
    parameter  int unsigned TS_W     = 18,
    localparam int unsigned IDX_W    = $clog2(CHANNELS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CHANNELS-1:0]       strobe,
    input  logic [CHANNELS*AMP_W-1:0] amp_flat,
    input  logic [TS_W-1:0]           ts_now,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          clr_idx,
    output logic [CHANNELS-1:0]       pending,
    output logic [CHANNELS*AMP_W-1:0] amp_held,
    output logic [CHANNELS*TS_W-1:0]  ts_held
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic             pend_q;
        logic [AMP_W-1:0] amp_q;
        logic [TS_W-1:0]  ts_q;

        // R3: first strike wins; the slot is freed only by a FIFO write
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
                amp_q  <= '0;
                ts_q   <= '0;
            end else if (pend_q) begin
                if (clr_en && (clr_idx == IDX_W'(c)))
                    pend_q <= 1'b0;
            end else if (strobe[c]) begin
                pend_q <= 1'b1;
                amp_q  <= amp_flat[c*AMP_W +: AMP_W];
                ts_q   <= ts_now;
            end
        end

        assign pending[c]                  = pend_q;
        assign amp_held[c*AMP_W +: AMP_W]  = amp_q;
        assign ts_held[c*TS_W +: TS_W]     = ts_q;
    end

endmodule

// File: rtl/evt_rr_arbiter.sv
module evt_rr_arbiter #(
    parameter  int unsigned CHANNELS = 64,
    localparam int unsigned IDX_W    = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] req,
    input  logic                take,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_idx
);

    logic [IDX_W-1:0] start_q;
    int               pos;
    logic [IDX_W-1:0] cand;

    // R4: scan starts at start_q and wraps over the channel range
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        pos         = 0;
        cand        = '0;
        for (int k = 0; k < int'(CHANNELS); k++) begin
            pos = int'(start_q) + k;
            if (pos >= int'(CHANNELS))
                pos = pos - int'(CHANNELS);
            cand = IDX_W'(pos);
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            start_q <= '0;
        else if (take)
            start_q <= (grant_idx == IDX_W'(CHANNELS - 1)) ? '0 : grant_idx + 1'b1;
    end

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
    parameter  int unsigned WIDTH = 30,
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp_q;
    logic [AW:0]      rp_q;

    assign empty   = (wp_q == rp_q);
    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign rd_data = mem[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wp_q[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_en)
                wp_q <= wp_q + 1'b1;
            if (rd_en)
                rp_q <= rp_q + 1'b1;
        end
    end

endmodule

// File: rtl/evt_token_ser.sv
module evt_token_ser
    import evt_pkg::*;
#(
    parameter  int unsigned WIDTH = 30,
    localparam int unsigned CW    = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_in,
    input  logic             fifo_empty,
    input  logic [WIDTH-1:0] fifo_word,
    output logic             pop,
    output logic             tok_out,
    output logic             ser_en,
    output logic             ser_bit,
    output logic             ser_frame
);

    tok_state_e       st_q;
    logic             busy_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] sh_q;
    logic             tok_out_q;
    logic             slot_free;
    logic             holding;
    logic             release_now;

    assign holding     = (st_q == TOK_HOLD);
    assign slot_free   = !busy_q || (cnt_q == '0);
    assign pop         = holding && slot_free && !fifo_empty;
    assign release_now = holding && slot_free && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= TOK_WAIT;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            sh_q      <= '0;
            tok_out_q <= 1'b0;
        end else begin
            tok_out_q <= release_now;
            if (st_q == TOK_WAIT) begin
                if (tok_in)
                    st_q <= TOK_HOLD;
            end else if (release_now) begin
                st_q <= TOK_WAIT;
            end
            if (pop) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(WIDTH - 1);
                sh_q   <= fifo_word;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    sh_q  <= {sh_q[WIDTH-2:0], 1'b0};
                end
            end
        end
    end

    assign tok_out   = tok_out_q;
    assign ser_en    = busy_q;
    assign ser_bit   = sh_q[WIDTH-1];
    assign ser_frame = busy_q && (cnt_q == CW'(WIDTH - 1));

endmodule

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo
    import evt_pkg::*;
#(
    parameter  int unsigned CHANNELS = DEF_CHANNELS,
    parameter  int unsigned AMP_W    = DEF_AMP_W,
    parameter  int unsigned TS_W     = DEF_TS_W,
    parameter  int unsigned DEPTH    = DEF_DEPTH,
    localparam int unsigned IDX_W    = $clog2(CHANNELS),
    localparam int unsigned WORD_W   = IDX_W + AMP_W + TS_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CHANNELS-1:0]       hit_strobe,
    input  logic [CHANNELS*AMP_W-1:0] hit_amp,
    input  logic                      tok_in,
    output logic                      tok_out,
    output logic                      ser_en,
    output logic                      ser_bit,
    output logic                      ser_frame
);

    typedef struct packed {
        logic [IDX_W-1:0] chan;
        logic [AMP_W-1:0] amp;
        logic [TS_W-1:0]  stamp;
    } evt_word_t;

    logic [TS_W-1:0]           ts_q;
    logic [CHANNELS-1:0]       pending;
    logic [CHANNELS*AMP_W-1:0] amp_held;
    logic [CHANNELS*TS_W-1:0]  ts_held;
    logic                      grant_valid;
    logic [IDX_W-1:0]          grant_idx;
    logic                      fifo_wr;
    logic                      fifo_rd;
    logic                      fifo_full;
    logic                      fifo_empty;
    evt_word_t                 wr_word;
    logic [WORD_W-1:0]         rd_word;

    // R2: free-running stamp with explicit rollover
    always_ff @(posedge clk) begin
        if (rst)
            ts_q <= '0;
        else if (ts_q == {TS_W{1'b1}})
            ts_q <= '0;
        else
            ts_q <= ts_q + 1'b1;
    end

    evt_hit_latch #(
        .CHANNELS (CHANNELS),
        .AMP_W    (AMP_W),
        .TS_W     (TS_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .strobe   (hit_strobe),
        .amp_flat (hit_amp),
        .ts_now   (ts_q),
        .clr_en   (fifo_wr),
        .clr_idx  (grant_idx),
        .pending  (pending),
        .amp_held (amp_held),
        .ts_held  (ts_held)
    );

    evt_rr_arbiter #(
        .CHANNELS (CHANNELS)
    ) u_arb (
        .clk         (clk),
        .rst         (rst),
        .req         (pending),
        .take        (fifo_wr),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    // R5: a full FIFO holds the grant back, the channel stays pending
    assign fifo_wr       = grant_valid && !fifo_full;
    assign wr_word.chan  = grant_idx;
    assign wr_word.amp   = amp_held[grant_idx*AMP_W +: AMP_W];
    assign wr_word.stamp = ts_held[grant_idx*TS_W +: TS_W];

    evt_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_wr),
        .wr_data (wr_word),
        .rd_en   (fifo_rd),
        .rd_data (rd_word),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    evt_token_ser #(
        .WIDTH (WORD_W)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .tok_in     (tok_in),
        .fifo_empty (fifo_empty),
        .fifo_word  (rd_word),
        .pop        (fifo_rd),
        .tok_out    (tok_out),
        .ser_en     (ser_en),
        .ser_bit    (ser_bit),
        .ser_frame  (ser_frame)
    );

endmodule

// File: rtl/evt_stamp_fifo_chk.sv
module evt_stamp_fifo_chk #(
    parameter int unsigned CHANNELS = 64,
    parameter int unsigned TS_W     = 18,
    parameter int unsigned IDX_W    = 6
) (
    input logic                clk,
    input logic                rst,
    input logic [TS_W-1:0]     ts,
    input logic                wr_en,
    input logic [IDX_W-1:0]    grant_idx,
    input logic [CHANNELS-1:0] pending,
    input logic                fifo_full,
    input logic                fifo_rd,
    input logic                tok_out,
    input logic                ser_en,
    input logic                ser_frame
);

    localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

    assert_ts_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ts != TS_MAX) |=> (ts == $past(ts) + 1'b1));

    assert_ts_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (ts == TS_MAX) |=> (ts == '0));

    assert_clear_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !pending[$past(grant_idx)]);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !fifo_rd) |=> fifo_full);

    assert_tok_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);

    assert_quiet_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> !ser_en);

    assert_frame_inside_R8: assert property (@(posedge clk) disable iff (rst)
        ser_frame |-> ser_en);

    assert_frame_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        ser_frame |=> !ser_frame);

endmodule

bind evt_stamp_fifo evt_stamp_fifo_chk #(
    .CHANNELS (CHANNELS),
    .TS_W     (TS_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ts        (ts_q),
    .wr_en     (fifo_wr),
    .grant_idx (grant_idx),
    .pending   (pending),
    .fifo_full (fifo_full),
    .fifo_rd   (fifo_rd),
    .tok_out   (tok_out),
    .ser_en    (ser_en),
    .ser_frame (ser_frame)
);

// File: tb/evt_stamp_fifo_bench.sv
module evt_stamp_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 64;
    localparam int AMPW  = 6;
    localparam int TSW   = 10;
    localparam int DEP   = 64;
    localparam int IDXW  = 6;
    localparam int WORDW = IDXW + AMPW + TSW;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCH-1:0]       hit_strobe = '0;
    logic [NCH*AMPW-1:0]  hit_amp = '0;
    logic                 tok_in = 1'b0;
    logic                 tok_out;
    logic                 ser_en;
    logic                 ser_bit;
    logic                 ser_frame;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int tok_cyc = -1;
    bit window = 1'b0;
    bit done = 1'b0;
    bit prev_tok = 1'b0;
    logic [WORDW-1:0] exp_q[$];
    logic [WORDW-1:0] rx_q[$];
    logic [WORDW-1:0] cur = '0;
    int bitn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_fifo #(
        .CHANNELS (NCH),
        .AMP_W    (AMPW),
        .TS_W     (TSW),
        .DEPTH    (DEP)
    ) u_evt_stamp_fifo (
        .clk        (clk),
        .rst        (rst),
        .hit_strobe (hit_strobe),
        .hit_amp    (hit_amp),
        .tok_in     (tok_in),
        .tok_out    (tok_out),
        .ser_en     (ser_en),
        .ser_bit    (ser_bit),
        .ser_frame  (ser_frame)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // serial receiver and line monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (ser_en) begin
                if (ser_frame) begin
                    if (bitn != 0) check(1'b0, "R8 frame inside word", bitn, 0);
                    bitn = 0;
                end
                cur = {cur[WORDW-2:0], ser_bit};
                bitn++;
                if (bitn == WORDW) begin
                    rx_q.push_back(cur);
                    bitn = 0;
                end
                if (!window) check(1'b0, "R10 line driven without token", 1, 0);
            end
            if (tok_out) begin
                if (prev_tok) check(1'b0, "R6 token pulse longer than one cycle", 1, 0);
                tok_cyc = cyc;
            end
            prev_tok = tok_out;
        end
    end

    function automatic logic [WORDW-1:0] mk_word(input int ch, input logic [AMPW-1:0] amp, input int c);
        return {IDXW'(ch), amp, TSW'(c)};
    endfunction

    task automatic tick();
        @(negedge clk);
        #1;
        hit_strobe = '0;
        tok_in = 1'b0;
    endtask

    task automatic arm(input int ch, input logic [AMPW-1:0] amp);
        hit_strobe[ch] = 1'b1;
        hit_amp[ch*AMPW +: AMPW] = amp;
    endtask

    task automatic strike(input int ch, input logic [AMPW-1:0] amp);
        arm(ch, amp);
        exp_q.push_back(mk_word(ch, amp, cyc));
    endtask

    task automatic read_out(input int n, input string req);
        int c0;
        int waited;
        logic [WORDW-1:0] e;
        logic [WORDW-1:0] g;
        rx_q.delete();
        tok_cyc = -1;
        window = 1'b1;
        c0 = cyc;
        tok_in = 1'b1;
        tick();
        waited = 0;
        while (tok_cyc < 0 && waited < n*WORDW + 50) begin
            tick();
            waited++;
        end
        window = 1'b0;
        check(tok_cyc == c0 + 2 + n*WORDW, "R7 token release cycle", tok_cyc, c0 + 2 + n*WORDW);
        check(rx_q.size() == n, "R7 word count", rx_q.size(), n);
        for (int i = 0; i < n; i++) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            g = (rx_q.size() > 0) ? rx_q.pop_front() : '1;
            check(g == e, req, g, e);
        end
    endtask

    initial begin
        int r;
        int prev_ch;
        int ch;
        int gap;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        #1;
        rst = 1'b0;
        // R9: reset state
        check(ser_en == 1'b0, "R9 ser_en after reset", ser_en, 0);
        check(ser_frame == 1'b0, "R9 ser_frame after reset", ser_frame, 0);
        check(tok_out == 1'b0, "R9 tok_out after reset", tok_out, 0);
        repeat (3) tick();
        check(tok_out == 1'b0 && ser_en == 1'b0, "R9 idle without token", {tok_out, ser_en}, 0);

        // R6: empty chip passes the token one cycle later
        read_out(0, "R6 empty pass");
        repeat (3) tick();

        // R4: simultaneous strikes, wrapped search order
        arm(9, 6'h09); arm(2, 6'h02); arm(5, 6'h05);
        exp_q.push_back(mk_word(2, 6'h02, cyc));
        exp_q.push_back(mk_word(5, 6'h05, cyc));
        exp_q.push_back(mk_word(9, 6'h09, cyc));
        tick();
        repeat (4) tick();
        arm(1, 6'h31); arm(12, 6'h2c);
        exp_q.push_back(mk_word(12, 6'h2c, cyc));
        exp_q.push_back(mk_word(1, 6'h31, cyc));
        tick();
        repeat (4) tick();
        read_out(5, "R4 round-robin order");
        repeat (3) tick();

        // R1 R2: random single strikes
        prev_ch = -1;
        for (int i = 0; i < 40; i++) begin
            r = int'($urandom_range(NCH - 1, 0));
            ch = (r == prev_ch) ? (r + 1) % NCH : r;
            strike(ch, AMPW'($urandom));
            prev_ch = ch;
            tick();
            gap = int'($urandom_range(2, 0));
            repeat (gap) tick();
        end
        repeat (3) tick();
        read_out(40, "R1 R2 random word content");
        repeat (3) tick();

        // R5 R3: fill the FIFO, then strike while full
        for (int i = 0; i < NCH; i++) begin
            strike(i, AMPW'(i ^ 21));
            tick();
        end
        repeat (3) tick();
        arm(20, 6'h0a);
        tick();
        arm(7, 6'h0b);
        tick();
        arm(40, 6'h0c);
        tick();
        // expected entries after the full set: channel 7, then 20, then 40
        exp_q.push_back(mk_word(7, 6'h0b, cyc - 2));
        exp_q.push_back(mk_word(20, 6'h0a, cyc - 3));
        exp_q.push_back(mk_word(40, 6'h0c, cyc - 1));
        arm(7, 6'h3f);
        tick();
        arm(20, 6'h3e);
        tick();
        repeat (5) tick();
        read_out(NCH + 3, "R5 R3 full blocking and pending hold");
        repeat (3) tick();

        // R2: strikes across the timestamp rollover
        while ((cyc % (1 << TSW)) != (1 << TSW) - 1) tick();
        strike(3, 6'h13);
        tick();
        check((cyc % (1 << TSW)) == 0, "R2 bench at rollover", cyc % (1 << TSW), 0);
        strike(4, 6'h14);
        tick();
        repeat (4) tick();
        read_out(2, "R2 rollover stamps");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule